// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Port

This block holds the configuration bytes of a legacy PC chipset and makes them reachable through two byte-wide I/O locations. Software first writes a register number to the index location. A later write to the data location stores a byte into the numbered register, and a read of the data location returns it. Some registers keep only some of their bits; the bits they drop always read back as zero.

Two control outputs come from the stored contents. The external cache enable follows two bits of the cache control register. A one-cycle change pulse tells the memory map logic to recompute the shadow map after any of the three shadow control registers is written. The bus is a simple synchronous strobe interface. Read data is registered and appears in the cycle after the read strobe.

Top module: `cfg_regport`

## Requirements
- R1: A write strobe with address 0x0022 loads the 8-bit write data into the index latch. Subsequent data-port accesses use that value to select a register.
- R2: A write strobe with address 0x0024 stores the write data, after that register's keep-mask, into the register selected by the index. The new value is visible from the clock edge that samples the strobe.
- R3: Register 0 keeps only bits 6:0, so bit 7 always reads back as 0.
- R4: Register 12 keeps the write data ANDed with 0xCF, so bits 5:4 always read back as 0.
- R5: Registers 1 to 11 and 13 to 17 keep all eight bits unchanged.
- R6: A read strobe at 0x0024 puts the selected register on rdata in the cycle after the strobe. A read strobe at any other address puts 0xFF there. rdata holds its value while no read strobe is present.
- R7: When the index is 18 or more, a data-port write changes no register, and a data-port read returns 0xFF.
- R8: cache_en is high exactly when bit 2 or bit 3 of register 2 is set. It changes on the same edge as register 2.
- R9: shadow_update is high for exactly one cycle after each data-port write with index 4, 5 or 6. It stays low after all other writes.
- R10: A synchronous active-high reset clears the index and all registers to 0x00, sets rdata to 0xFF, and drives cache_en and shadow_update low.
- R11: When read and write strobes hit the data port in the same cycle, rdata returns the register's value from before the write, and the write still takes effect.
- R12: Writes to addresses other than 0x0022 and 0x0024 change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | I/O address of the current access |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| cache_en | output | 1 | External cache enable from register 2 |
| shadow_update | output | 1 | One-cycle pulse after a shadow register write |

## Verification
A read and a write of the data port can land in the same cycle. The bench provokes this by raising both strobes together at 0x0024 on a register whose content it already knows. It expects rdata to carry the old value, and a later plain read to return the new, masked value. The bench also raises both strobes together at the index port. There it expects 0xFF on rdata and the new index to be in force for the next access.

// File: rtl/cfg_regport_pkg.sv
package cfg_regport_pkg;
  localparam int DW        = 8;
  localparam int AW        = 16;
  localparam int NUM_REGS  = 18;
  localparam int CACHE_REG = 2;
  localparam int SHAD_LO   = 4;
  localparam int SHAD_HI   = 6;
  localparam logic [DW-1:0] CACHE_BITS = 8'h0C;
  localparam logic [DW-1:0] IDLE_READ  = 8'hFF;

  // Per-register keep-mask applied to data-port writes.
  function automatic logic [DW-1:0] keep_mask(input int unsigned n);
    case (n)
      0:       keep_mask = 8'h7F;
      12:      keep_mask = 8'hCF;
      default: keep_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_regport_decode.sv
module cfg_regport_decode
  import cfg_regport_pkg::*;
#(
  parameter logic [AW-1:0] IDX_PORT  = 16'h0022,
  parameter logic [AW-1:0] DATA_PORT = 16'h0024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] idx_q,
  output logic          data_wr,
  output logic          data_rd
);
  logic hit_idx, hit_data;

  always_comb begin
    hit_idx  = (addr == IDX_PORT);
    hit_data = (addr == DATA_PORT);
    data_wr  = wr && hit_data;
    data_rd  = rd && hit_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                idx_q <= '0;
    else if (wr && hit_idx) idx_q <= wdata;
  end

  // R1: index port write lands in the latch
  a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == IDX_PORT) |=> (idx_q == $past(wdata)));
  // R12: any other write leaves the index alone
  a_r12_index_hold: assert property (@(posedge clk) disable iff (rst)
    (!(wr && addr == IDX_PORT)) |=> $stable(idx_q));
endmodule

// File: rtl/cfg_regport_regfile.sv
module cfg_regport_regfile
  import cfg_regport_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DW-1:0]          sel,
  input  logic                   data_wr,
  input  logic                   data_rd,
  input  logic                   any_rd,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  localparam int SW = $clog2(NUM_REGS);

  logic [DW-1:0] regs_q [NUM_REGS];
  logic          in_range;
  logic [SW-1:0] sel_s;
  logic [DW-1:0] rd_val;

  always_comb begin
    in_range = (sel < DW'(NUM_REGS));
    sel_s    = sel[SW-1:0];
    rd_val   = in_range ? regs_q[sel_s] : IDLE_READ;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] KEEP = keep_mask(g);
    always_ff @(posedge clk) begin
      if (rst)                                regs_q[g] <= '0;
      else if (data_wr && sel == DW'(g))      regs_q[g] <= wdata & KEEP;
    end
    assign regs_flat[g*DW +: DW] = regs_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= IDLE_READ;
    else if (any_rd) rdata <= data_rd ? rd_val : IDLE_READ;
  end

  // R3: register 0 never holds bit 7
  a_r3_reg0_msb: assert property (@(posedge clk) disable iff (rst)
    regs_flat[7] == 1'b0);
  // R4: register 12 never holds bits 5:4
  a_r4_reg12_gap: assert property (@(posedge clk) disable iff (rst)
    regs_flat[12*DW+5 -: 2] == 2'b00);
  // R7: out-of-range data write changes nothing
  a_r7_oob_ignored: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !in_range) |=> $stable(regs_flat));
  // R6: non-data read yields the idle pattern
  a_r6_idle_read: assert property (@(posedge clk) disable iff (rst)
    (any_rd && !data_rd) |=> (rdata == IDLE_READ));
  // R6: no read strobe, rdata holds
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!any_rd) |=> $stable(rdata));
endmodule

// File: rtl/cfg_regport_side.sv
module cfg_regport_side
  import cfg_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sel,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          cache_en,
  output logic          shadow_update
);
  logic hit_cache, hit_shadow;

  always_comb begin
    hit_cache  = data_wr && (sel == DW'(CACHE_REG));
    hit_shadow = data_wr && (sel >= DW'(SHAD_LO)) && (sel <= DW'(SHAD_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_en      <= 1'b0;
      shadow_update <= 1'b0;
    end else begin
      if (hit_cache) cache_en <= |(wdata & keep_mask(CACHE_REG) & CACHE_BITS);
      shadow_update <= hit_shadow;
    end
  end
endmodule

// File: rtl/cfg_regport.sv
module cfg_regport
  import cfg_regport_pkg::*;
#(
  parameter logic [AW-1:0] IDX_PORT  = 16'h0022,
  parameter logic [AW-1:0] DATA_PORT = 16'h0024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          cache_en,
  output logic          shadow_update
);
  logic [DW-1:0]          idx_q;
  logic                   data_wr, data_rd;
  logic [NUM_REGS*DW-1:0] regs_flat;

  cfg_regport_decode #(.IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .idx_q(idx_q), .data_wr(data_wr), .data_rd(data_rd)
  );

  cfg_regport_regfile u_rf (
    .clk(clk), .rst(rst), .sel(idx_q), .data_wr(data_wr), .data_rd(data_rd),
    .any_rd(rd), .wdata(wdata), .rdata(rdata), .regs_flat(regs_flat)
  );

  cfg_regport_side u_side (
    .clk(clk), .rst(rst), .sel(idx_q), .data_wr(data_wr), .wdata(wdata),
    .cache_en(cache_en), .shadow_update(shadow_update)
  );

  // R8: cache enable tracks register 2 contents
  a_r8_cache_tracks: assert property (@(posedge clk) disable iff (rst)
    cache_en == |(regs_flat[CACHE_REG*DW +: DW] & CACHE_BITS));
  // R9: a pulse only follows a shadow register write
  a_r9_shadow_cause: assert property (@(posedge clk) disable iff (rst)
    shadow_update |-> ($past(wr) && $past(addr) == DATA_PORT &&
                       $past(idx_q) >= DW'(SHAD_LO) && $past(idx_q) <= DW'(SHAD_HI)));
  // R9: every shadow register write gives a pulse
  a_r9_shadow_fires: assert property (@(posedge clk) disable iff (rst)
    (data_wr && idx_q >= DW'(SHAD_LO) && idx_q <= DW'(SHAD_HI)) |=> shadow_update);
endmodule

// File: tb/cfg_regport_test.sv
module cfg_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDX  = 16'h0022;
  localparam logic [15:0] DATA = 16'h0024;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic cache_en, shadow_update;

  int checks = 0, fails = 0;
  logic [7:0] model [18];

  cfg_regport uut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr),
                   .rd(rd), .rdata(rdata), .cache_en(cache_en),
                   .shadow_update(shadow_update));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bmask(input int n);
    if (n == 0)  return 8'h7F;
    if (n == 12) return 8'hCF;
    return 8'hFF;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic reg_write(input int n, input logic [7:0] d);
    io_write(IDX, 8'(n));
    io_write(DATA, d);
    if (n < 18) model[n] = d & bmask(n);
  endtask

  task automatic reg_read(input int n, output logic [7:0] d);
    io_write(IDX, 8'(n));
    io_read(DATA, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R10 rdata after reset", rdata, 8'hFF);
    check("R10 cache_en after reset", {7'd0, cache_en}, 8'h00);
    check("R10 shadow_update after reset", {7'd0, shadow_update}, 8'h00);
    for (int n = 0; n < 18; n++) begin
      reg_read(n, v);
      check("R10 register cleared", v, 8'h00);
    end
  endtask

  task automatic t_fill;
    logic [7:0] v;
    for (int n = 0; n < 18; n++) reg_write(n, 8'((n * 53) ^ 8'hA5) | 8'h80);
    for (int n = 0; n < 18; n++) begin
      reg_read(n, v);
      check("R1 R2 R5 readback", v, model[n]);
    end
  endtask

  task automatic t_masks;
    logic [7:0] v;
    reg_write(0, 8'hFF);  reg_read(0, v);  check("R3 reg0 bit7 dropped", v, 8'h7F);
    reg_write(12, 8'hFF); reg_read(12, v); check("R4 reg12 bits 5:4 dropped", v, 8'hCF);
    reg_write(12, 8'h30); reg_read(12, v); check("R4 reg12 only dropped bits", v, 8'h00);
    reg_write(17, 8'hFF); reg_read(17, v); check("R5 reg17 full byte", v, 8'hFF);
  endtask

  task automatic t_out_of_range;
    logic [7:0] v;
    reg_write(18, 8'h3C);
    reg_write(8'hFF, 8'h3C);
    reg_read(18, v);  check("R7 read beyond last", v, 8'hFF);
    reg_read(255, v); check("R7 read at 0xFF index", v, 8'hFF);
    for (int n = 0; n < 18; n++) begin
      reg_read(n, v);
      check("R7 no register touched", v, model[n]);
    end
  endtask

  task automatic t_other_addr;
    logic [7:0] v;
    io_write(IDX, 8'd9);
    io_write(16'h0023, 8'h01);
    io_write(16'h0124, 8'h5E);
    io_write(16'h0122, 8'h02);
    io_read(DATA, v);
    check("R12 stray writes ignored", v, model[9]);
    io_read(16'h0023, v); check("R6 read at other address", v, 8'hFF);
    io_read(IDX, v);      check("R6 read at index port", v, 8'hFF);
    repeat (2) @(negedge clk);
    check("R6 rdata holds without strobe", rdata, 8'hFF);
  endtask

  task automatic t_cache;
    reg_write(2, 8'h04); check("R8 bit2 sets cache_en", {7'd0, cache_en}, 8'h01);
    reg_write(2, 8'h00); check("R8 cleared", {7'd0, cache_en}, 8'h00);
    reg_write(2, 8'h08); check("R8 bit3 sets cache_en", {7'd0, cache_en}, 8'h01);
    reg_write(2, 8'hF3); check("R8 other bits only", {7'd0, cache_en}, 8'h00);
    reg_write(3, 8'hFF); check("R8 other register no effect", {7'd0, cache_en}, 8'h00);
  endtask

  task automatic t_shadow;
    for (int n = 3; n <= 7; n++) begin
      io_write(IDX, 8'(n));
      check("R9 quiet after index write", {7'd0, shadow_update}, 8'h00);
      io_write(DATA, 8'h55);
      model[n] = 8'h55;
      check("R9 pulse after data write", {7'd0, shadow_update},
            (n >= 4 && n <= 6) ? 8'h01 : 8'h00);
      @(negedge clk);
      check("R9 pulse lasts one cycle", {7'd0, shadow_update}, 8'h00);
    end
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    reg_write(1, 8'h11);
    @(negedge clk); addr = DATA; wdata = 8'h99; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    model[1] = 8'h99;
    check("R11 read sees old value", rdata, 8'h11);
    io_read(DATA, v); check("R11 write took effect", v, 8'h99);
    reg_write(0, 8'h22);
    @(negedge clk); addr = DATA; wdata = 8'hF0; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    model[0] = 8'h70;
    check("R11 old value on reg0", rdata, 8'h22);
    io_read(DATA, v); check("R11 R3 masked new value", v, 8'h70);
    @(negedge clk); addr = IDX; wdata = 8'd5; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    check("R6 index port read during index write", rdata, 8'hFF);
    io_read(DATA, v); check("R1 index from same-cycle write", v, model[5]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 18; n++) model[n] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_masks();
    t_out_of_range();
    t_other_addr();
    t_cache();
    t_shadow();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule